// File: doc/BRIEF.md
# Greedy Ternary Frame Ordering Engine

This block takes a set of ternary scan frames (0, 1 or don't-care per position, one position per test pattern) and emits them in an order where neighbouring frames conflict as little as possible. Frames are written into an internal register file while the engine is idle. A start pulse then runs one selection step per clock. Each step picks the closest remaining frame to a running reference frame. The candidate may be taken as stored or bitwise complemented. The engine emits the chosen frame's index, a complement flag and the frame with its don't-care positions resolved. It then folds the choice into the reference.

The reference is not just the last frame emitted. Where the chosen frame is don't-care, the reference keeps its old value. Where the chosen frame contradicts the reference, that position becomes don't-care, because the run of equal values has ended there. The reference starts fully don't-care at the start of a run. The first step therefore needs no special case: frame 0 wins at distance zero and is emitted as stored. Any leftover don't-care values in the output are left for a later fill pass.

Top module: `frame_reorder`

## Requirements
- R1: Each position is a 2-bit code: 00 is a 0, 01 is a 1, and 10 or 11 is a don't-care. Every output frame writes a don't-care as 10, never as 11.
- R2: The output from the first clock edge after the start edge is index 0, flag 0, and frame 0 exactly as stored, with any 11 written as 10.
- R3: The distance between two frames is the number of positions where both hold a 0 or 1 and the two values differ. Each step picks a remaining candidate with the smallest distance to the reference.
- R4: Candidates are every remaining frame as stored (flag 0) and complemented (flag 1). Complementing swaps 0 and 1 and leaves don't-care alone. Once a frame is chosen in either form, neither form is offered again in the same run.
- R5: On equal distance the lowest frame index wins, and for the same frame the stored form wins over the complemented form.
- R6: In the emitted frame, a don't-care position of the chosen (possibly complemented) frame takes the reference value at that position.
- R7: After each step, each reference position updates as follows. It keeps its old value where the chosen frame is don't-care. It becomes don't-care where the chosen value and the reference value are opposite 0/1 values. Otherwise it takes the chosen value.
- R8: A run emits exactly N_FRAMES valid outputs on consecutive cycles. done_o rises on the same edge as the last output, stays high until the next start is accepted, and is low from that start edge on.
- R9: While a run is in progress, writes and start pulses have no effect. A later run over the same frames gives the same outputs.
- R10: While reset is held, and after its release until a run completes, out_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write a frame into the register file (idle only) |
| wr_idx_i | input | IDX_W | Frame slot to write; slots at or above N_FRAMES are ignored |
| wr_frame_i | input | 2*WIDTH | Frame to store, 2 bits per position |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| out_valid_o | output | 1 | One step's result is present |
| out_idx_o | output | IDX_W | Index of the chosen frame |
| out_flip_o | output | 1 | Chosen frame was taken complemented |
| out_frame_o | output | 2*WIDTH | Chosen frame with don't-cares resolved from the reference |
| done_o | output | 1 | All frames of the last run have been emitted |

## Verification
The assertions assume that every run starts from a fully loaded register file and that start_i arrives only while the engine is idle or is meant to be dropped. Under those assumptions each emitted index is unique within a run, the first emitted choice is frame 0 in stored form, and no more than N_FRAMES results appear. The stimulus loads all slots before each start. It pushes a write and a start into the middle of one run on purpose and expects both to be dropped. The hand-built frame sets are chosen so that distance ties, complement wins and a reference conflict each change the expected order or fill. A naive last-frame reference would produce a visibly different output.

// File: rtl/frame_reorder_pkg.sv
package frame_reorder_pkg;
  typedef logic [1:0] tern_t;
  localparam tern_t TERN_X = 2'b10;

  function automatic logic tern_is_x(tern_t t);
    return t[1];
  endfunction
endpackage

// File: rtl/fr_dist.sv
module fr_dist #(
  parameter int WIDTH  = 16,
  parameter int DIST_W = 5
) (
  input  logic [2*WIDTH-1:0] frame_i,
  input  logic [2*WIDTH-1:0] ref_i,
  output logic [DIST_W-1:0]  dist_plain_o,
  output logic [DIST_W-1:0]  dist_flip_o
);
  always_comb begin
    dist_plain_o = '0;
    dist_flip_o  = '0;
    for (int p = 0; p < WIDTH; p++) begin
      if (!frame_i[2*p+1] && !ref_i[2*p+1]) begin
        // both care: a mismatch hurts the plain form, a match hurts the flipped form
        if (frame_i[2*p] != ref_i[2*p]) dist_plain_o += DIST_W'(1);
        else                            dist_flip_o  += DIST_W'(1);
      end
    end
  end
endmodule

// File: rtl/fr_argmin.sv
module fr_argmin #(
  parameter int N_FRAMES = 8,
  parameter int DIST_W   = 5,
  parameter int IDX_W    = 3
) (
  input  logic [DIST_W-1:0]   dist_plain_i [N_FRAMES],
  input  logic [DIST_W-1:0]   dist_flip_i  [N_FRAMES],
  input  logic [N_FRAMES-1:0] avail_i,
  output logic [IDX_W-1:0]    sel_idx_o,
  output logic                sel_flip_o
);
  logic [DIST_W-1:0] best;
  logic              have;

  // scan order index-ascending, plain before flip; strict compare keeps the first
  always_comb begin
    best       = '1;
    have       = 1'b0;
    sel_idx_o  = '0;
    sel_flip_o = 1'b0;
    for (int i = 0; i < N_FRAMES; i++) begin
      if (avail_i[i]) begin
        if (!have || dist_plain_i[i] < best) begin
          best = dist_plain_i[i]; have = 1'b1;
          sel_idx_o = IDX_W'(i); sel_flip_o = 1'b0;
        end
        if (dist_flip_i[i] < best) begin
          best = dist_flip_i[i];
          sel_idx_o = IDX_W'(i); sel_flip_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fr_ref_update.sv
module fr_ref_update
  import frame_reorder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2*WIDTH-1:0] chosen_i,
  input  logic               flip_i,
  input  logic [2*WIDTH-1:0] ref_i,
  output logic [2*WIDTH-1:0] filled_o,
  output logic [2*WIDTH-1:0] ref_next_o
);
  always_comb begin
    for (int p = 0; p < WIDTH; p++) begin
      tern_t c, r;
      c = chosen_i[2*p +: 2];
      r = ref_i[2*p +: 2];
      if (tern_is_x(c)) begin
        filled_o[2*p +: 2]   = r;
        ref_next_o[2*p +: 2] = r;
      end else begin
        c = {1'b0, c[0] ^ flip_i};
        filled_o[2*p +: 2] = c;
        if (!tern_is_x(r) && r[0] != c[0]) ref_next_o[2*p +: 2] = TERN_X;
        else                               ref_next_o[2*p +: 2] = c;
      end
    end
  end
endmodule

// File: rtl/frame_reorder.sv
module frame_reorder
  import frame_reorder_pkg::*;
#(
  parameter int N_FRAMES = 8,
  parameter int WIDTH    = 16,
  localparam int IDX_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [2*WIDTH-1:0] wr_frame_i,
  input  logic               start_i,
  output logic               out_valid_o,
  output logic [IDX_W-1:0]   out_idx_o,
  output logic               out_flip_o,
  output logic [2*WIDTH-1:0] out_frame_o,
  output logic               done_o
);
  localparam int DIST_W = $clog2(WIDTH + 1);
  localparam int CNT_W  = $clog2(N_FRAMES + 1);

  logic [2*WIDTH-1:0]  frames_q [N_FRAMES];
  logic [2*WIDTH-1:0]  ref_q, ref_next, filled;
  logic [N_FRAMES-1:0] avail_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                busy_q;
  logic [DIST_W-1:0]   dist_p [N_FRAMES];
  logic [DIST_W-1:0]   dist_f [N_FRAMES];
  logic [IDX_W-1:0]    sel_idx;
  logic                sel_flip;

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_dist
    fr_dist #(.WIDTH(WIDTH), .DIST_W(DIST_W)) u_dist (
      .frame_i      (frames_q[g]),
      .ref_i        (ref_q),
      .dist_plain_o (dist_p[g]),
      .dist_flip_o  (dist_f[g])
    );
  end

  fr_argmin #(.N_FRAMES(N_FRAMES), .DIST_W(DIST_W), .IDX_W(IDX_W)) u_argmin (
    .dist_plain_i (dist_p),
    .dist_flip_i  (dist_f),
    .avail_i      (avail_q),
    .sel_idx_o    (sel_idx),
    .sel_flip_o   (sel_flip)
  );

  fr_ref_update #(.WIDTH(WIDTH)) u_ref (
    .chosen_i   (frames_q[sel_idx]),
    .flip_i     (sel_flip),
    .ref_i      (ref_q),
    .filled_o   (filled),
    .ref_next_o (ref_next)
  );

  always_ff @(posedge clk_i) begin
    if (!busy_q && wr_en_i && 32'(wr_idx_i) < N_FRAMES) frames_q[wr_idx_i] <= wr_frame_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_o      <= 1'b0;
      cnt_q       <= '0;
      avail_q     <= '0;
      ref_q       <= '0;
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      out_flip_o  <= 1'b0;
      out_frame_o <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          done_o  <= 1'b0;
          cnt_q   <= '0;
          avail_q <= '1;
          // all-X reference: frame 0 wins step 0 at distance 0, emitted as stored
          ref_q   <= {WIDTH{TERN_X}};
        end
      end else begin
        out_valid_o      <= 1'b1;
        out_idx_o        <= sel_idx;
        out_flip_o       <= sel_flip;
        out_frame_o      <= filled;
        ref_q            <= ref_next;
        avail_q[sel_idx] <= 1'b0;
        cnt_q            <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(N_FRAMES - 1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_reorder_chk.sv
module frame_reorder_chk #(
  parameter int N_FRAMES = 8,
  parameter int WIDTH    = 16,
  parameter int IDX_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_i,
  input logic               out_valid_o,
  input logic [IDX_W-1:0]   out_idx_o,
  input logic               out_flip_o,
  input logic [2*WIDTH-1:0] out_frame_o,
  input logic               done_o
);
  localparam int CNT_W = $clog2(N_FRAMES + 1);

  logic [(2**IDX_W)-1:0] seen_q;
  logic [CNT_W-1:0]      vcnt_q;
  logic                  any_11;

  always_comb begin
    any_11 = 1'b0;
    for (int p = 0; p < WIDTH; p++) any_11 |= (out_frame_o[2*p +: 2] == 2'b11);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      vcnt_q <= '0;
    end else begin
      if (out_valid_o) begin
        seen_q[out_idx_o] <= 1'b1;
        vcnt_q <= vcnt_q + CNT_W'(1);
      end
      if (start_i && !busy_i) begin
        seen_q <= '0;
        vcnt_q <= '0;
      end
    end
  end

  assert_canonical_x_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !any_11);
  assert_first_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && vcnt_q == '0) |-> (out_idx_o == '0 && !out_flip_o));
  assert_no_repeat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (!seen_q[out_idx_o] && 32'(out_idx_o) < N_FRAMES));
  assert_run_length_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> 32'(vcnt_q) < N_FRAMES);
  assert_done_with_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (out_valid_o && 32'(vcnt_q) == N_FRAMES - 1));
  assert_idle_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_i) |=> $stable(done_o));
endmodule

bind frame_reorder frame_reorder_chk #(
  .N_FRAMES (N_FRAMES),
  .WIDTH    (WIDTH),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_i      (busy_q),
  .out_valid_o (out_valid_o),
  .out_idx_o   (out_idx_o),
  .out_flip_o  (out_flip_o),
  .out_frame_o (out_frame_o),
  .done_o      (done_o)
);

// File: tb/sim_frame_reorder.sv
`timescale 1ns/1ps
module sim_frame_reorder;
  localparam int N  = 4;
  localparam int W  = 6;
  localparam int IW = 2;
  localparam int NC = 3;

  // string position 0 is the MSB; X mask bit set means don't-care
  localparam logic [W-1:0] IN_V [NC*N] = '{
    6'b000000, 6'b111111, 6'b000000, 6'b000000,
    6'b001100, 6'b000100, 6'b000000, 6'b000000,
    6'b100001, 6'b001011, 6'b110000, 6'b010000};
  localparam logic [W-1:0] IN_X [NC*N] = '{
    6'b000000, 6'b000000, 6'b010101, 6'b111111,
    6'b000011, 6'b000011, 6'b111111, 6'b001011,
    6'b001100, 6'b000100, 6'b000000, 6'b101010};
  localparam int EXP_I [NC*N] = '{0, 1, 2, 3,  0, 2, 1, 3,  0, 3, 1, 2};
  localparam bit EXP_F [NC*N] = '{0, 1, 0, 0,  0, 0, 0, 0,  0, 1, 0, 1};
  localparam logic [W-1:0] EXP_V [NC*N] = '{
    6'b000000, 6'b000000, 6'b000000, 6'b000000,
    6'b001100, 6'b001100, 6'b000100, 6'b000000,
    6'b100001, 6'b100101, 6'b001111, 6'b001111};
  localparam logic [W-1:0] EXP_X [NC*N] = '{
    6'b000000, 6'b000000, 6'b000000, 6'b000000,
    6'b000011, 6'b000011, 6'b000011, 6'b001011,
    6'b001100, 6'b001000, 6'b000000, 6'b000000};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [IW-1:0]  wr_idx = '0;
  logic [2*W-1:0] wr_frame = '0;
  logic out_valid, out_flip, done;
  logic [IW-1:0]  out_idx;
  logic [2*W-1:0] out_frame;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  frame_reorder #(.N_FRAMES(N), .WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_frame_i(wr_frame), .start_i(start), .out_valid_o(out_valid),
    .out_idx_o(out_idx), .out_flip_o(out_flip), .out_frame_o(out_frame),
    .done_o(done));

  // inputs use both X codes (10 and 11); expected frames use 10 only
  function automatic logic [2*W-1:0] enc(logic [W-1:0] v, logic [W-1:0] x, bit as_input);
    logic [2*W-1:0] r;
    for (int p = 0; p < W; p++)
      r[2*p +: 2] = x[p] ? ((as_input && p % 2 == 1) ? 2'b11 : 2'b10) : {1'b0, v[p]};
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(int c);
    for (int f = 0; f < N; f++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(f); wr_frame = enc(IN_V[c*N+f], IN_X[c*N+f], 1'b1);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int c, bit disturb);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R8", "done cleared by start", int'(done), 0);
    if (disturb) begin
      // R9: overwrite slot 3 and re-start mid-run; both must be dropped
      wr_en = 1'b1; wr_idx = IW'(3); wr_frame = '0; start = 1'b1;
    end
    for (int k = 0; k < N; k++) begin
      int e;
      logic [2*W-1:0] ef;
      string ri, rf, rw;
      e  = c*N + k;
      ef = enc(EXP_V[e], EXP_X[e], 1'b0);
      ri = (k == 0) ? "R2" : ((c == 0) ? "R5" : "R3");
      rf = (k == 0) ? "R2" : "R4";
      rw = (k == 0) ? "R1" : ((c == 1 && k == 3) ? "R7" : (disturb ? "R9" : "R6"));
      @(posedge clk); #1;
      chk(out_valid == 1'b1, "R8", $sformatf("valid case %0d step %0d", c, k), int'(out_valid), 1);
      chk(int'(out_idx) == EXP_I[e], ri, $sformatf("index case %0d step %0d", c, k), int'(out_idx), EXP_I[e]);
      chk(out_flip == EXP_F[e], rf, $sformatf("flip case %0d step %0d", c, k), int'(out_flip), int'(EXP_F[e]));
      chk(out_frame == ef, rw, $sformatf("frame case %0d step %0d", c, k), int'(out_frame), int'(ef));
      if (disturb && k == 0) begin
        wr_en = 1'b0; start = 1'b0;
      end
    end
    chk(done == 1'b1, "R8", "done with last output", int'(done), 1);
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R8", "no output after run", int'(out_valid), 0);
    chk(done == 1'b1, "R8", "done held", int'(done), 1);
  endtask

  initial begin
    #4;
    chk(out_valid == 1'b0 && done == 1'b0, "R10", "outputs in reset", int'({out_valid, done}), 0);
    #8 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0 && done == 1'b0, "R10", "outputs after reset", int'({out_valid, done}), 0);
    for (int c = 0; c < NC; c++) begin
      load(c);
      run(c, 1'b0);
    end
    run(2, 1'b1);
    run(2, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule